// File: doc/BRIEF.md
# Byte-Counting Transmit/Receive FIFO Pair with Event Register

This block sits between a register bus and a serial shift engine. It holds two byte-wide queues of 32 entries each: one carries bytes from software toward the shifter, the other carries received bytes back to software. Software moves 1, 2 or 4 bytes per access through one data register for each direction. Any mix of access widths can be used, because both queues count single bytes rather than words. The shift engine pops transmit bytes and pushes receive bytes one at a time.

An event register combines two kinds of information. The first is live occupancy: bytes waiting in the receive queue and free space in the transmit queue. The second is a set of sticky status flags that software clears by writing ones. A mask register selects which flags drive the interrupt line. A control register holds the threshold levels for both directions and the enable and loopback settings used by the shift engine.

Top module: `bf_fifo_pair`

## Requirements
- R1: Each queue holds 32 bytes. The access size code sets how many bytes one access moves: 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 move 4 bytes. The register addresses are 0 control, 1 event, 2 mask, 3 transmit data and 4 receive data.
- R2: Event bits [29:24] hold the number of bytes in the receive queue. Event bits [21:16] hold the free space in the transmit queue, so an empty transmit queue reads 32. All other count-area bits read 0.
- R3: Within an access, the most significant byte of the accessed width is the first byte in the queue. A 16-bit write takes wdata[15:8] first and then wdata[7:0]; an 8-bit write takes wdata[7:0]. Receive reads return the bytes right-aligned and zero-extended.
- R4: Each flag is set by its own condition:
  - bit 15: the transmit queue is empty.
  - bit 14: the engine pulsed done.
  - bit 13: the receive count is greater than the receive threshold.
  - bit 12: the receive queue is full.
  - bit 11: the transmit count is less than the transmit threshold.
  - bit 9: the receive queue is not empty.
  - bit 8: the transmit queue is not full.
  - All other bits read 0.
- R5: Flags are sticky and update one cycle after their condition. Writing a 1 to a flag position of the event register clears that flag. A flag whose condition still holds is set again by that same update.
- R6: The interrupt is high exactly when some flag and its mask bit are both 1. Only the seven flag positions of the mask register can be written.
- R7: The control register holds enable at bit 31, loopback at bit 30, the transmit threshold at bits [13:8] and the receive threshold at bits [5:0]. It resets to 0x0000040F, and all other bits read 0.
- R8: Writes to the event register never change the count fields.
- R9: These accesses are ignored and leave both queues unchanged:
  - a transmit write larger than the free space;
  - a receive read larger than the fill, which returns 0;
  - an engine pop from an empty transmit queue;
  - an engine push into a full receive queue.
- R10: cfg_enable and cfg_loopback follow control bits 31 and 30.
- R11: After reset both queues are empty, all flags are clear and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on receive data) |
| bus_addr | input | 3 | Register index |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_byte | output | 8 | Head byte of the transmit queue |
| rx_push | input | 1 | Engine delivers one receive byte |
| rx_byte | input | 8 | Received byte |
| xfer_done | input | 1 | Engine transfer-complete pulse |
| cfg_enable | output | 1 | Control enable bit |
| cfg_loopback | output | 1 | Control loopback bit |
| event_word | output | 32 | Live event register value |
| irq | output | 1 | Interrupt request |

## Verification
The bound assertions check on every cycle that both count fields stay within the queue depth. They also check that a transmit write into a full queue and a receive read of an empty queue leave the counts as they were. Finally, they check that a done pulse always raises its flag and that the interrupt never rises with all flags clear. The following can only be shown by the bench's scenarios, because each depends on a particular history of accesses:
- byte ordering across mixed access widths;
- rejection of oversize partial accesses;
- threshold edges;
- flag re-assertion after a clear;
- masked interrupt behaviour.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int FLAG_TXE = 15;
    localparam int FLAG_DON = 14;
    localparam int FLAG_RXT = 13;
    localparam int FLAG_RXF = 12;
    localparam int FLAG_TXT = 11;
    localparam int FLAG_RNE = 9;
    localparam int FLAG_TNF = 8;
    localparam logic [15:0] FLAG_MASK_BITS = 16'hFB00;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_EVENT  = 3'd1,
        RA_MASK   = 3'd2,
        RA_TXDATA = 3'd3,
        RA_RXDATA = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        AS_BYTE = 2'd0,
        AS_HALF = 2'd1,
        AS_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic       enable;
        logic       loopback;
        logic [5:0] tx_thr;
        logic [5:0] rx_thr;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{enable: 1'b0, loopback: 1'b0,
                                     tx_thr: 6'd4, rx_thr: 6'd15};

    function automatic logic [2:0] access_bytes(input logic [1:0] sz);
        case (sz)
            AS_BYTE: return 3'd1;
            AS_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        return {c.enable, c.loopback, 16'b0, c.tx_thr, 2'b0, c.rx_thr};
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.enable   = w[31];
        c.loopback = w[30];
        c.tx_thr   = w[13:8];
        c.rx_thr   = w[5:0];
        return c;
    endfunction

endpackage

// File: rtl/bf_byte_queue.sv
module bf_byte_queue #(
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [2:0]                   push_n,
    input  logic [31:0]                  push_data,
    input  logic [2:0]                   pop_n,
    output logic [31:0]                  head_data,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            cnt_q  <= cnt_q + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < push_n)
                mem[wr_ptr + AW'(i)] <= push_data[31-8*i -: 8];
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_head
        assign head_data[31-8*g -: 8] = mem[rd_ptr + AW'(g)];
    end

    assign count = cnt_q;

endmodule

// File: rtl/bf_event_ctrl.sv
module bf_event_ctrl
    import bf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_ctrl,
    input  logic                         wr_mask,
    input  logic                         wr_event,
    input  logic [31:0]                  wdata,
    input  logic [$clog2(DEPTH+1)-1:0]   tx_count,
    input  logic [$clog2(DEPTH+1)-1:0]   rx_count,
    input  logic                         done_pulse,
    output ctrl_t                        ctrl,
    output logic [15:0]                  mask,
    output logic [15:0]                  flags,
    output logic                         irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [15:0] cond;
    logic [15:0] clr;
    logic [15:0] flags_q;
    logic [15:0] mask_q;
    ctrl_t       ctrl_q;

    always_comb begin
        cond           = '0;
        cond[FLAG_TXE] = (tx_count == '0);
        cond[FLAG_DON] = done_pulse;
        cond[FLAG_RXT] = (rx_count > CW'(ctrl_q.rx_thr));
        cond[FLAG_RXF] = (rx_count == CW'(DEPTH));
        cond[FLAG_TXT] = (tx_count < CW'(ctrl_q.tx_thr));
        cond[FLAG_RNE] = (rx_count != '0);
        cond[FLAG_TNF] = (tx_count != CW'(DEPTH));
        clr            = wr_event ? wdata[15:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
            ctrl_q  <= CTRL_RESET;
        end else begin
            flags_q <= (cond | (flags_q & ~clr)) & FLAG_MASK_BITS;
            if (wr_mask)
                mask_q <= wdata[15:0] & FLAG_MASK_BITS;
            if (wr_ctrl)
                ctrl_q <= ctrl_unpack(wdata);
        end
    end

    assign ctrl  = ctrl_q;
    assign mask  = mask_q;
    assign flags = flags_q;
    assign irq   = |(flags_q & mask_q);

endmodule

// File: rtl/bf_fifo_pair.sv
module bf_fifo_pair
    import bf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        xfer_done,
    output logic        cfg_enable,
    output logic        cfg_loopback,
    output logic [31:0] event_word,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [2:0]    nbytes;
    logic [CW-1:0] tx_count, rx_count, tx_free;
    logic [31:0]   tx_head, rx_head, tx_wdata_al, rx_rdata_al;
    logic          tx_acc, rx_acc;
    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    ctrl_t         ctrl;
    logic [15:0]   mask, flags;

    assign nbytes  = access_bytes(bus_size);
    assign tx_free = CW'(DEPTH) - tx_count;
    assign tx_acc  = bus_wr && (bus_addr == RA_TXDATA) && (CW'(nbytes) <= tx_free);
    assign rx_acc  = bus_rd && (bus_addr == RA_RXDATA) && (CW'(nbytes) <= rx_count);

    always_comb begin
        case (bus_size)
            AS_BYTE: tx_wdata_al = {bus_wdata[7:0], 24'b0};
            AS_HALF: tx_wdata_al = {bus_wdata[15:0], 16'b0};
            default: tx_wdata_al = bus_wdata;
        endcase
        case (bus_size)
            AS_BYTE: rx_rdata_al = {24'b0, rx_head[31:24]};
            AS_HALF: rx_rdata_al = {16'b0, rx_head[31:16]};
            default: rx_rdata_al = rx_head;
        endcase
    end

    assign tx_push_n = tx_acc ? nbytes : 3'd0;
    assign tx_pop_n  = (tx_pop && tx_count != '0) ? 3'd1 : 3'd0;
    assign rx_push_n = (rx_push && rx_count != CW'(DEPTH)) ? 3'd1 : 3'd0;
    assign rx_pop_n  = rx_acc ? nbytes : 3'd0;

    bf_byte_queue #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push_n(tx_push_n), .push_data(tx_wdata_al),
        .pop_n(tx_pop_n), .head_data(tx_head), .count(tx_count)
    );

    bf_byte_queue #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push_n(rx_push_n), .push_data({rx_byte, 24'b0}),
        .pop_n(rx_pop_n), .head_data(rx_head), .count(rx_count)
    );

    bf_event_ctrl #(.DEPTH(DEPTH)) u_evt (
        .clk(clk), .rst(rst),
        .wr_ctrl (bus_wr && bus_addr == RA_CTRL),
        .wr_mask (bus_wr && bus_addr == RA_MASK),
        .wr_event(bus_wr && bus_addr == RA_EVENT),
        .wdata(bus_wdata),
        .tx_count(tx_count), .rx_count(rx_count),
        .done_pulse(xfer_done),
        .ctrl(ctrl), .mask(mask), .flags(flags), .irq(irq)
    );

    assign tx_byte      = tx_head[31:24];
    assign cfg_enable   = ctrl.enable;
    assign cfg_loopback = ctrl.loopback;
    assign event_word   = {2'b0, 6'(rx_count), 2'b0, 6'(tx_free), flags};

    always_comb begin
        case (bus_addr)
            RA_CTRL:   bus_rdata = ctrl_pack(ctrl);
            RA_EVENT:  bus_rdata = event_word;
            RA_MASK:   bus_rdata = {16'b0, mask};
            RA_RXDATA: bus_rdata = rx_acc ? rx_rdata_al : 32'b0;
            default:   bus_rdata = 32'b0;
        endcase
    end

endmodule

// File: rtl/bf_fifo_pair_chk.sv
module bf_fifo_pair_chk #(
    parameter int DEPTH = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic        tx_pop,
    input logic        rx_push,
    input logic        xfer_done,
    input logic [31:0] event_word,
    input logic        irq
);
    assert_txfree_bound_R2: assert property (@(posedge clk) disable iff (rst)
        event_word[21:16] <= 6'(DEPTH));

    assert_rxfill_bound_R2: assert property (@(posedge clk) disable iff (rst)
        event_word[29:24] <= 6'(DEPTH));

    assert_full_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3 && event_word[21:16] == 6'd0 && !tx_pop)
        |=> (event_word[21:16] == 6'd0));

    assert_empty_read_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd4 && event_word[29:24] == 6'd0 && !rx_push)
        |=> (event_word[29:24] == 6'd0));

    assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> event_word[14]);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (event_word[15:8] != 8'd0));

endmodule

bind bf_fifo_pair bf_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/bf_fifo_pair_bench.sv
module bf_fifo_pair_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        xfer_done = 1'b0;
    logic        cfg_enable, cfg_loopback, irq;
    logic [31:0] event_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench loopback: every engine pop delivers that byte to the receive side
    bf_fifo_pair u_bf_fifo_pair (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte),
        .rx_push(tx_pop), .rx_byte(tx_byte),
        .xfer_done(xfer_done),
        .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback),
        .event_word(event_word), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 read and compare, 2 engine move
        logic [2:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd3, 2'd2, 32'hA1B2C3D4, 32'h0, 4'd3},   // R3 word push
        '{2'd0, 3'd3, 2'd1, 32'h0000E5F6, 32'h0, 4'd3},   // R3 half push
        '{2'd0, 3'd3, 2'd0, 32'h00000077, 32'h0, 4'd3},   // R3 byte push
        '{2'd0, 3'd1, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd5},   // R5 clear all
        '{2'd1, 3'd1, 2'd2, 32'h0, 32'h0019_0100, 4'd8},  // R8 R2 counts survive clear
        '{2'd2, 3'd0, 2'd0, 32'd7, 32'h0, 4'd1},          // R1 move 7 bytes
        '{2'd0, 3'd1, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd5},   // R5 clear all
        '{2'd1, 3'd1, 2'd2, 32'h0, 32'h0720_8B00, 4'd4},  // R4 flags after move
        '{2'd1, 3'd4, 2'd2, 32'h0, 32'hA1B2C3D4, 4'd3},   // R3 word read order
        '{2'd1, 3'd4, 2'd2, 32'h0, 32'h00000000, 4'd9},   // R9 word read with 3 left
        '{2'd1, 3'd4, 2'd1, 32'h0, 32'h0000E5F6, 4'd3},   // R3 half read
        '{2'd1, 3'd4, 2'd0, 32'h0, 32'h00000077, 4'd3},   // R3 byte read
        '{2'd1, 3'd4, 2'd0, 32'h0, 32'h00000000, 4'd9},   // R9 empty read
        '{2'd0, 3'd0, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd7},   // R7 ctrl all ones
        '{2'd1, 3'd0, 2'd2, 32'h0, 32'hC000_3F3F, 4'd7},  // R7 defined fields only
        '{2'd0, 3'd0, 2'd2, 32'h0000040F, 32'h0, 4'd7},   // R7 restore
        '{2'd0, 3'd2, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd6},   // R6 mask all ones
        '{2'd1, 3'd2, 2'd2, 32'h0, 32'h0000_FB00, 4'd6},  // R6 flag bits only
        '{2'd0, 3'd2, 2'd2, 32'h00000000, 32'h0, 4'd6}    // R6 mask clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    task automatic bus_op(input logic wr, input logic rd, input logic [2:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd_val);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz; bus_wdata = wd;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic move(input int n);
        @(negedge clk);
        tx_pop = 1'b1;
        repeat (n) @(negedge clk);
        tx_pop = 1'b0;
    endtask

    logic [31:0] rv;

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state: empty queues, flags clear, mask zero
        check("R11 event at reset", event_word, 32'h0020_0000);
        check("R11 irq at reset", {31'b0, irq}, 32'h0);
        bus_op(1'b0, 1'b1, 3'd0, 2'd2, 32'h0, rv);
        check("R7 ctrl reset value", rv, 32'h0000_040F);
        bus_op(1'b0, 1'b1, 3'd2, 2'd2, 32'h0, rv);
        check("R11 mask reset", rv, 32'h0);
        check("R10 cfg bits at reset", {30'b0, cfg_enable, cfg_loopback}, 32'h0);
        check("R4 idle flags", event_word, 32'h0020_8900);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind == 2'd2)
                move(int'(VECS[i].data));
            else begin
                bus_op(VECS[i].kind == 2'd0, VECS[i].kind == 2'd1, VECS[i].addr,
                       VECS[i].size, VECS[i].data, rv);
                if (VECS[i].kind == 2'd1)
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), rv, VECS[i].expv);
            end
            if (i == 13)
                check("R10 cfg bits follow ctrl", {30'b0, cfg_enable, cfg_loopback}, 32'h3);
        end

        // R5 R6: done flag and masked interrupt
        bus_op(1'b1, 1'b0, 3'd2, 2'd2, 32'h0000_4000, rv);
        check("R6 irq masked flags only", {31'b0, irq}, 32'h0);
        @(negedge clk) xfer_done = 1'b1;
        @(negedge clk) xfer_done = 1'b0;
        check("R5 done flag set", {31'b0, event_word[14]}, 32'h1);
        check("R6 irq on done", {31'b0, irq}, 32'h1);
        bus_op(1'b1, 1'b0, 3'd1, 2'd2, 32'h0000_4000, rv);
        check("R5 done cleared by write-one", {31'b0, event_word[14]}, 32'h0);
        check("R6 irq drops after clear", {31'b0, irq}, 32'h0);
        bus_op(1'b1, 1'b0, 3'd2, 2'd2, 32'h0, rv);

        // R9 full transmit queue then overfill
        for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            b = 8'(k * 4);
            bus_op(1'b1, 1'b0, 3'd3, 2'd2, {b, b + 8'd1, b + 8'd2, b + 8'd3}, rv);
        end
        bus_op(1'b1, 1'b0, 3'd3, 2'd0, 32'h0000_00EE, rv);
        check("R9 write to full tx ignored", {26'b0, event_word[21:16]}, 32'h0);
        move(32);
        move(2);
        bus_op(1'b1, 1'b0, 3'd1, 2'd2, 32'hFFFF_FFFF, rv);
        check("R4 R9 rx full flags and count", event_word, 32'h2020_BB00);
        bus_op(1'b0, 1'b1, 3'd4, 2'd2, 32'h0, rv);
        check("R1 R3 first word after fill", rv, 32'h0001_0203);
        for (int k = 1; k < 8; k++) bus_op(1'b0, 1'b1, 3'd4, 2'd2, 32'h0, rv);
        check("R1 last of 32 bytes", rv, 32'h1C1D_1E1F);

        // R4 receive threshold edge at 3
        bus_op(1'b1, 1'b0, 3'd0, 2'd2, 32'h0000_0003, rv);
        bus_op(1'b1, 1'b0, 3'd3, 2'd2, 32'h1122_3344, rv);
        move(3);
        bus_op(1'b1, 1'b0, 3'd1, 2'd2, 32'hFFFF_FFFF, rv);
        check("R4 rx count equal to threshold", event_word, 32'h031F_0300);
        move(1);
        bus_op(1'b1, 1'b0, 3'd1, 2'd2, 32'hFFFF_FFFF, rv);
        check("R4 rx count above threshold", event_word, 32'h0420_A300);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule